// File: doc/BRIEF.md
# Compare-Match Interval Timer

A memory-mapped interval timer with one or more independent channels and a single run register that all channels share. Each channel owns a control/status register, an up-counter and a compare register. While its run bit is set, a channel's prescaler divides the functional clock by 8, 32, 128 or 512. On every prescaled tick the counter either advances or, once it equals the compare value, returns to zero and raises a match flag. A channel drives its own interrupt line whenever a flag is set and the channel's interrupt enable is on.

A parameter chooses between two variants. The narrow one has 16-bit counter and compare registers at a 6-byte window. The wide one has 32-bit counter and compare registers and a second flag that records a pass through all-ones. Software clears a flag by writing the control/status register back with that flag bit at zero.

The register port is a single-cycle write strobe with byte addressing. Read data is combinational from the address.

Top module: `match_timer`

## Requirements
- R1: After reset the run register, every control/status register and every counter read 0, every compare register reads all-ones (0xFFFF narrow, 0xFFFFFFFF wide), and all interrupt lines are low.
- R2: The run register is at byte address 0x00. Bit c runs channel c, and a write stores all bits as written. Channel c's window starts at 0x10 + 0x10*c with control/status at +0. The counter is at +2 (narrow) or +4 (wide), and the compare register is at +4 (narrow) or +8 (wide). Unmapped addresses read 0.
- R3: Control/status bits [1:0] select the tick period: 0, 1, 2 and 3 give 8, 32, 128 and 512 clock cycles. A channel whose run bit is clear holds its counter, and its prescaler restarts from zero.
- R4: On a tick the counter advances by one, except when it equals the compare value. In that case it becomes 0 and the match flag is set, so one period is compare+1 ticks.
- R5: Control/status reads back the match flag at bit 7 and interrupt enable at bit 6 (narrow), or the match flag at bit 15, the wrap flag at bit 14 and interrupt enable at bit 5 (wide), with the divider select at [1:0]. All other bits read 0.
- R6: A control/status write with a flag bit at 0 clears that flag, and a write with the bit at 1 leaves it unchanged.
- R7: If a flag is set and cleared by a write in the same cycle, the flag ends up set.
- R8: A channel's interrupt is high exactly when its interrupt enable is set and one of its flags is set. Writing 0 to control/status drops it.
- R9: The compare and counter registers can be written while the channel runs. A counter write that lands on a tick replaces that tick's update.
- R10: In the wide variant, a counter above the compare value that ticks at all-ones becomes 0 and sets the wrap flag at bit 14, not the match flag. In the narrow variant the counter simply rolls over to 0 with no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, low bits used for narrower registers |
| bus_rdata | output | 32 | Read data for bus_addr, zero-extended |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
Two functions can meet in one cycle: a tick that sets the match flag and a software write that clears that same flag, or a tick and a software write to the counter. The bench uses its own model to find the clock edge on which a tick, and for the flag case a match, is due. It places the conflicting write exactly there. The outcome is judged on every clock by the model comparison and afterwards by reading the register back: the flag must remain set, and the counter must hold the written value.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

   // prescaler counter width: must hold the largest divide minus one (511)
   localparam int PRE_W     = 10;
   // each channel window spans 16 bytes
   localparam int WIN_SHIFT = 4;

   function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
      return (PRE_W'(8) << (2 * sel)) - PRE_W'(1);
   endfunction

   function automatic logic [WIN_SHIFT-1:0] cnt_ofs(input bit wide);
      return wide ? WIN_SHIFT'(4) : WIN_SHIFT'(2);
   endfunction

   function automatic logic [WIN_SHIFT-1:0] cmp_ofs(input bit wide);
      return wide ? WIN_SHIFT'(8) : WIN_SHIFT'(4);
   endfunction

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler
   import match_timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);

   logic [PRE_W-1:0] pcnt_q;

   assign tick = run && (pcnt_q >= pre_limit(sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pcnt_q <= '0;
      else if (!run)   pcnt_q <= '0;
      else if (tick)   pcnt_q <= '0;
      else             pcnt_q <= pcnt_q + 1'b1;
   end

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/mt_channel.sv
module mt_channel
   import match_timer_pkg::*;
#(
   parameter bit WIDE  = 1'b1,
   parameter int CNT_W = WIDE ? 32 : 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ctrl_wr,
   input  logic             cnt_wr,
   input  logic             cmp_wr,
   input  logic [31:0]      wdata,
   output logic [15:0]      ctrl_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cmp_q,
   output logic             irq
);

   localparam int FLAG_BIT = WIDE ? 15 : 7;
   localparam int IE_BIT   = WIDE ? 5 : 6;

   logic [1:0] sel_q;
   logic       ie_q;
   logic       mflag_q;
   logic       oflag;
   logic       tick;
   logic       hit;
   logic       mset;
   logic       mclr;
   logic       unused_wbits;

   assign unused_wbits = ^wdata;

   mt_prescaler u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .sel  (sel_q),
      .tick (tick)
   );

   assign hit  = (cnt_q == cmp_q);
   assign mset = tick && !cnt_wr && hit;
   assign mclr = ctrl_wr && !wdata[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (cnt_wr)  cnt_q <= wdata[CNT_W-1:0];
      else if (tick)    cnt_q <= hit ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cmp_q <= '1;
      else if (cmp_wr)  cmp_q <= wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         ie_q    <= 1'b0;
         mflag_q <= 1'b0;
      end else begin
         mflag_q <= mset || (mflag_q && !mclr);
         if (ctrl_wr) begin
            sel_q <= wdata[1:0];
            ie_q  <= wdata[IE_BIT];
         end
      end
   end

   generate
      if (WIDE) begin : g_wide
         logic oflag_q;
         logic oset;
         assign oset = tick && !cnt_wr && !hit && (&cnt_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oflag_q <= 1'b0;
            else        oflag_q <= oset || (oflag_q && !(ctrl_wr && !wdata[14]));
         end
         assign oflag  = oflag_q;
         assign ctrl_q = {mflag_q, oflag_q, 8'b0, ie_q, 3'b0, sel_q};

         // R10
         ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            oset |=> (cnt_q == '0) && oflag_q);
      end else begin : g_narrow
         assign oflag  = 1'b0;
         assign ctrl_q = {8'b0, mflag_q, ie_q, 4'b0, sel_q};
      end
   endgenerate

   assign irq = ie_q && (mflag_q || oflag);

   // R4
   match_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mset |=> (cnt_q == '0) && mflag_q);

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt_q));

   // R9
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt_q == $past(wdata[CNT_W-1:0]));

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mset && ctrl_wr) |=> mflag_q);

   // R6
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mclr && !mset) |=> !mflag_q);

endmodule

// File: rtl/match_timer.sv
module match_timer
   import match_timer_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter bit WIDE   = 1'b1,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq
);

   localparam int CNT_W  = WIDE ? 32 : 16;
   localparam int SEL_W  = ADDR_W - WIN_SHIFT;
   localparam logic [WIN_SHIFT-1:0] CNT_OFS = cnt_ofs(WIDE);
   localparam logic [WIN_SHIFT-1:0] CMP_OFS = cmp_ofs(WIDE);

   generate
      if (ADDR_W <= WIN_SHIFT || ADDR_W > 16) begin : g_bad_addr
         $error("match_timer: ADDR_W out of range");
      end
      if (NUM_CH < 1 || NUM_CH > 16 || (NUM_CH + 1) > (1 << (ADDR_W - WIN_SHIFT))) begin : g_bad_ch
         $error("match_timer: NUM_CH does not fit the address map");
      end
   endgenerate

   logic [NUM_CH-1:0]       start_q;
   logic                    start_wr;
   logic [WIN_SHIFT-1:0]    ofs;
   logic [NUM_CH-1:0][31:0] rd_ch;

   assign start_wr = bus_wr && (bus_addr == '0);
   assign ofs      = bus_addr[WIN_SHIFT-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        start_q <= '0;
      else if (start_wr) start_q <= bus_wdata[NUM_CH-1:0];
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic             hit;
         logic [15:0]      ctrl;
         logic [CNT_W-1:0] cnt;
         logic [CNT_W-1:0] cmp;

         assign hit = (bus_addr[ADDR_W-1:WIN_SHIFT] == SEL_W'(c + 1));

         mt_channel #(.WIDE(WIDE), .CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (start_q[c]),
            .ctrl_wr(bus_wr && hit && (ofs == '0)),
            .cnt_wr (bus_wr && hit && (ofs == CNT_OFS)),
            .cmp_wr (bus_wr && hit && (ofs == CMP_OFS)),
            .wdata  (bus_wdata),
            .ctrl_q (ctrl),
            .cnt_q  (cnt),
            .cmp_q  (cmp),
            .irq    (irq[c])
         );

         always_comb begin
            rd_ch[c] = '0;
            if (hit) begin
               if (ofs == '0)          rd_ch[c] = 32'(ctrl);
               else if (ofs == CNT_OFS) rd_ch[c] = 32'(cnt);
               else if (ofs == CMP_OFS) rd_ch[c] = 32'(cmp);
            end
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = start_wr ? 32'(start_q) : 32'(start_q);
      if (bus_addr != '0) bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) bus_rdata = bus_rdata | rd_ch[c];
   end

   // R2
   start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_wr |=> $stable(start_q));

endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // index 0: narrow variant, index 1: wide variant
   logic [7:0]  b_addr [2];
   logic        b_wr   [2];
   logic [31:0] b_wd   [2];
   wire  [31:0] b_rd   [2];
   wire  [1:0]  b_irq  [2];

   match_timer #(.NUM_CH(2), .WIDE(1'b0), .ADDR_W(8)) dut_n (
      .clk(clk), .rst_n(rst_n), .bus_addr(b_addr[0]), .bus_wr(b_wr[0]),
      .bus_wdata(b_wd[0]), .bus_rdata(b_rd[0]), .irq(b_irq[0]));

   match_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(b_addr[1]), .bus_wr(b_wr[1]),
      .bus_wdata(b_wd[1]), .bus_rdata(b_rd[1]), .irq(b_irq[1]));

   int    checks = 0;
   int    failures = 0;
   bit    done = 0;
   string phase = "R1";

   // ---------------- reference model ----------------
   int     m_pre [2][2];
   int     m_sel [2][2];
   longint m_cnt [2][2];
   longint m_cmp [2][2];
   bit     m_mf  [2][2];
   bit     m_of  [2][2];
   bit     m_ie  [2][2];
   bit [1:0] m_run [2];

   function automatic int lim(int s);
      return (8 << (2 * s)) - 1;
   endfunction
   function automatic longint mask(int v);
      return v ? 64'hFFFF_FFFF : 64'hFFFF;
   endfunction
   function automatic int fbit(int v);  return v ? 15 : 7; endfunction
   function automatic int iebit(int v); return v ? 5 : 6;  endfunction
   function automatic int cofs(int v);  return v ? 4 : 2;  endfunction
   function automatic int mofs(int v);  return v ? 8 : 4;  endfunction

   initial begin
      for (int v = 0; v < 2; v++) begin
         m_run[v] = 0; b_addr[v] = 0; b_wr[v] = 0; b_wd[v] = 0;
         for (int c = 0; c < 2; c++) begin
            m_pre[v][c] = 0; m_sel[v][c] = 0; m_cnt[v][c] = 0;
            m_cmp[v][c] = mask(v); m_mf[v][c] = 0; m_of[v][c] = 0; m_ie[v][c] = 0;
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         for (int v = 0; v < 2; v++) begin
            int a; int ch; int of; longint wd; bit [1:0] st;
            a = int'(b_addr[v]); ch = (a >> 4) - 1; of = a & 15; wd = longint'(b_wd[v]);
            st = m_run[v];
            for (int c = 0; c < 2; c++) begin
               bit tk, wk, wc, wm, ms, os;
               tk = st[c] && (m_pre[v][c] >= lim(m_sel[v][c]));
               m_pre[v][c] = !st[c] ? 0 : (tk ? 0 : m_pre[v][c] + 1);
               wk = b_wr[v] && ch == c && of == 0;
               wc = b_wr[v] && ch == c && of == cofs(v);
               wm = b_wr[v] && ch == c && of == mofs(v);
               ms = tk && !wc && (m_cnt[v][c] == m_cmp[v][c]);
               os = (v == 1) && tk && !wc && (m_cnt[v][c] != m_cmp[v][c]) && (m_cnt[v][c] == mask(v));
               if (wc) m_cnt[v][c] = wd & mask(v);
               else if (tk) m_cnt[v][c] = (m_cnt[v][c] == m_cmp[v][c]) ? 0 : ((m_cnt[v][c] + 1) & mask(v));
               if (wm) m_cmp[v][c] = wd & mask(v);
               m_mf[v][c] = ms || (m_mf[v][c] && !(wk && !wd[fbit(v)]));
               m_of[v][c] = os || (m_of[v][c] && !(wk && !wd[14]));
               if (wk) begin
                  m_sel[v][c] = int'(wd & 3);
                  m_ie[v][c]  = wd[iebit(v)];
               end
            end
            if (b_wr[v] && a == 0) m_run[v] = b_wd[v][1:0];
         end
      end
   end

   function automatic longint exp_rd(int v, int a);
      int ch; int of;
      if (a == 0) return longint'(m_run[v]);
      ch = (a >> 4) - 1; of = a & 15;
      if (ch < 0 || ch > 1) return 0;
      if (of == 0)
         return (longint'(m_mf[v][ch]) << fbit(v)) | (longint'(m_of[v][ch]) << 14) |
                (longint'(m_ie[v][ch]) << iebit(v)) | longint'(m_sel[v][ch]);
      if (of == cofs(v)) return m_cnt[v][ch];
      if (of == mofs(v)) return m_cmp[v][ch];
      return 0;
   endfunction

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison of every output against the model
   always @(posedge clk) begin
      #3;
      if (rst_n && !done) begin
         for (int v = 0; v < 2; v++) begin
            longint ei;
            ei = 0;
            for (int c = 0; c < 2; c++)
               if (m_ie[v][c] && (m_mf[v][c] || m_of[v][c])) ei |= (64'd1 << c);
            check(phase, longint'(b_rd[v]), exp_rd(v, int'(b_addr[v])));
            check({phase, " irq (R8)"}, longint'(b_irq[v]), ei);
         end
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(int v, int a, longint d);
      @(negedge clk);
      b_addr[v] = 8'(a); b_wd[v] = 32'(d); b_wr[v] = 1'b1;
      @(negedge clk);
      b_wr[v] = 1'b0;
   endtask

   task automatic rd(int v, int a, output longint d);
      @(negedge clk);
      b_addr[v] = 8'(a);
      #1 d = longint'(b_rd[v]);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // drive a write exactly into the cycle of channel c's next tick
   task automatic collide(int v, int c, bit need_match, int a, longint d);
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         if (m_run[v][c] && m_pre[v][c] >= lim(m_sel[v][c]) &&
             (!need_match || m_cnt[v][c] == m_cmp[v][c])) begin
            b_addr[v] = 8'(a); b_wd[v] = 32'(d); b_wr[v] = 1'b1;
            @(negedge clk);
            b_wr[v] = 1'b0;
            break;
         end
      end
   endtask

   task automatic run_variant(int v);
      longint d;
      int fb, ie;
      fb = fbit(v); ie = iebit(v);

      phase = "R1";
      rd(v, 'h10 + mofs(v), d); check("R1 compare reset", d, mask(v));
      rd(v, 'h10, d);           check("R1 control reset", d, 0);
      rd(v, 'h0, d);            check("R1 run reset", d, 0);
      check("R1 irq reset", longint'(b_irq[v]), 0);

      phase = "R4";
      wr(v, 'h10 + mofs(v), 3);
      wr(v, 'h10, 1 << ie);
      wr(v, 'h10 + cofs(v), 0);
      wr(v, 'h0, 1);
      idle(40);
      rd(v, 'h10, d); check("R4 match flag set", (d >> fb) & 1, 1);
      check("R8 irq raised", longint'(b_irq[v][0]), 1);

      phase = "R6";
      wr(v, 'h0, 0);
      wr(v, 'h10, (1 << ie) | (1 << fb));
      rd(v, 'h10, d); check("R6 flag kept on write of 1", (d >> fb) & 1, 1);
      wr(v, 'h10, 1 << ie);
      rd(v, 'h10, d); check("R6 flag cleared on write of 0", (d >> fb) & 1, 0);

      phase = "R2";
      wr(v, 'h20 + mofs(v), 1);
      wr(v, 'h20, (1 << ie) | 1);
      wr(v, 'h0, 2);
      rd(v, 'h10 + cofs(v), d);
      begin
         longint d2;
         idle(50);
         rd(v, 'h10 + cofs(v), d2);
         check("R3 stopped channel holds counter", d2, d);
      end
      idle(100);
      rd(v, 'h20, d); check("R2 channel 1 runs alone", (d >> fb) & 1, 1);
      rd(v, 'h10, d); check("R2 channel 0 stays idle", (d >> fb) & 1, 0);

      phase = "R7";
      wr(v, 'h0, 3);
      collide(v, 0, 1, 'h10, 1 << ie);
      rd(v, 'h10, d); check("R7 set beats clear", (d >> fb) & 1, 1);

      phase = "R9";
      wr(v, 'h10 + mofs(v), 5);
      collide(v, 0, 0, 'h10 + cofs(v), 2);
      rd(v, 'h10 + cofs(v), d); check("R9 counter write replaces tick", d, 2);
      idle(60);

      phase = "R10";
      wr(v, 'h0, 0);
      wr(v, 'h10, 1 << ie);
      wr(v, 'h10 + cofs(v), mask(v) - 1);
      wr(v, 'h0, 1);
      idle(30);
      rd(v, 'h10, d);
      check("R10 no match flag on roll-over", (d >> fb) & 1, 0);
      check("R10 wrap flag", (d >> 14) & 1, v);
      check("R10 irq from wrap flag", longint'(b_irq[v][0]), v);
      wr(v, 'h0, 0);
      wr(v, 'h10, (1 << ie) | (1 << fb));
      rd(v, 'h10, d); check("R6 wrap flag cleared", (d >> 14) & 1, 0);

      phase = "R3";
      wr(v, 'h20, (1 << ie) | 3);
      wr(v, 'h20 + cofs(v), 0);
      wr(v, 'h20 + mofs(v), 1);
      wr(v, 'h0, 2);
      idle(990);
      rd(v, 'h20, d); check("R3 divide-by-512 not yet wrapped", (d >> fb) & 1, 0);
      idle(50);
      rd(v, 'h20, d); check("R3 divide-by-512 wrapped", (d >> fb) & 1, 1);

      phase = "R5";
      wr(v, 'h0, 0);
      wr(v, 'h10, (1 << ie) | 2);
      rd(v, 'h10, d); check("R5 control readback", d, (1 << ie) | 2);
      rd(v, 'h12 + 8, d); check("R2 unmapped reads zero", d, 0);

      phase = "R8";
      wr(v, 'h10, 0);
      wr(v, 'h20, 0);
      idle(2);
      check("R8 irq low after control cleared", longint'(b_irq[v]), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run_variant(0);
      run_variant(1);
      idle(2);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule